// File: doc/BRIEF.md
# Table-Driven Daisy-Chain Identification Responder

This block stands in for a chain of memory devices on a nibble-wide host bus. A small table with up to eight entries lists the devices. Each entry holds a size code, a device type, a class, a last-chip nibble and a two-bit flag. The host enumerates the chain with identification requests. Each answered request returns a five-nibble code for the entry that is current. The host then sends a base address with configure commands. The block latches that base for the entry and moves its pointer past it.

Entries are visited in table order. An entry with a size code below 7 is passed over, and so is an entry with flag value 3. An entry flagged as stop is still enumerated, but once it has been configured the block answers nothing more. An entry flagged as hard-wired is never enumerated and is always reported as mapped at a fixed base. When nothing is left to enumerate, the block raises daisy-out. Further identification probes then get no answer, and the pointer does not wrap.

Every host strobe is sampled at a single point, a parameterized number of clocks into the strobe window. Values on the bus earlier in the window are ignored.

Top module: `idr_chain_responder`

## Requirements
- R1: After reset, no table-enumerated entry is mapped and all such bases read zero. `id_valid` is low. The next answered identification request returns the first eligible entry in table order, which also holds after a second reset.
- R2: An answered identification request (command code 1) puts out five nibbles on five consecutive cycles with `id_valid` high: size, then 0, then device type, then class, then the last-chip nibble.
- R3: In the fifth nibble, bits 3 and 2 come from the table and bits 1 and 0 are always 0.
- R4: Configure (command code 2) takes `ADDR_NIBS` nibbles, lowest nibble first. After the last one, the assembled base is stored for the current entry, that entry is marked mapped, and the pointer moves past it.
- R5: An entry whose size nibble is 6 or less, or whose flag is 3, is never presented; enumeration goes straight to the next entry.
- R6: Once an entry with flag 1 (stop) has been configured, later non-hard-wired entries are never presented, and `daisy_out` follows `daisy_in`.
- R7: An entry with flag 2 (hard-wired) and a valid size is never presented. Its `map_vld` bit is high at all times, including during reset, and its base reads `HW_BASE`. Unconfigure does not remove it.
- R8: With no eligible entry left, identification probes get no answer, and further probes still get none (no wrap to the first entry).
- R9: Unconfigure (command code 3) with nibble k < `N_ENT` clears the mapped bit and base of entry k, whatever the level of `daisy_in`.
- R10: Command and data are sampled once per strobe, on the clock edge where the strobe has been high for `SAMPLE_PT`+1 edges. Bus values before that edge, and strobes shorter than that, have no effect.
- R11: With `daisy_in` low, identification and configure commands have no effect and `daisy_out` is low. A mapped bit of a non-hard-wired entry can only rise after `daisy_in` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (host power-on) |
| tbl_size | input | 4*N_ENT | Size code per entry |
| tbl_type | input | 4*N_ENT | Device type per entry |
| tbl_class | input | 4*N_ENT | Device class per entry |
| tbl_last | input | 4*N_ENT | Last-chip nibble per entry |
| tbl_flag | input | 2*N_ENT | 0 continue, 1 stop, 2 hard-wired |
| bus_strobe | input | 1 | Host strobe window |
| bus_cmd | input | 2 | Decoded command: 0 none, 1 ID, 2 configure, 3 unconfigure |
| bus_nib | input | 4 | Host data nibble |
| daisy_in | input | 1 | Chain enable from the upstream device |
| daisy_out | output | 1 | Chain enable to the downstream device |
| id_valid | output | 1 | ID nibble valid |
| id_nib | output | 4 | ID nibble |
| map_vld | output | N_ENT | Entry is mapped |
| map_base | output | 4*ADDR_NIBS*N_ENT | Assigned base per entry |

## Verification
The bench builds the block with eight entries, three-nibble bases and a sample point of two. This keeps configure sequences short while keeping early-window junk and too-short strobes in play. Its table places an undersized entry and a flag-3 entry inside the enumeration path. It also puts a stop in the middle, with a continue entry after it, and includes two hard-wired entries. This lets skipping, stopping, probing after the end, unconfigure and reset re-entry all show up at the ports.

// File: rtl/idr_pkg.sv
package idr_pkg;
   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_ID    = 2'd1,
      CMD_CFG   = 2'd2,
      CMD_UNCFG = 2'd3
   } bus_cmd_e;

   typedef enum logic [1:0] {
      FL_CONT = 2'd0,
      FL_STOP = 2'd1,
      FL_HARD = 2'd2,
      FL_RSVD = 2'd3
   } ent_flag_e;

   localparam logic [3:0] MIN_SIZE = 4'h7;

   typedef struct packed {
      logic [3:0] size;
      logic [3:0] typ;
      logic [3:0] cls;
      logic [3:0] last;
   } id_word_t;
endpackage

// File: rtl/idr_sampler.sv
module idr_sampler
   import idr_pkg::*;
#(
   parameter int SAMPLE_PT = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe,
   input  logic [1:0] cmd_in,
   input  logic [3:0] nib_in,
   output logic       smp_valid,
   output bus_cmd_e   smp_cmd,
   output logic [3:0] smp_nib
);
   localparam int CNT_W = $clog2(SAMPLE_PT + 2);
   localparam logic [CNT_W-1:0] FIRE = CNT_W'(SAMPLE_PT);
   localparam logic [CNT_W-1:0] DONE = CNT_W'(SAMPLE_PT + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         smp_valid <= 1'b0;
         smp_cmd   <= CMD_NONE;
         smp_nib   <= 4'h0;
      end else begin
         smp_valid <= 1'b0;
         if (!strobe) begin
            cnt <= '0;
         end else begin
            if (cnt == FIRE) begin
               smp_valid <= 1'b1;
               smp_cmd   <= bus_cmd_e'(cmd_in);
               smp_nib   <= nib_in;
            end
            if (cnt != DONE) cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/idr_picker.sv
module idr_picker #(
   parameter int N_ENT = 8,
   parameter int IDX_W = 3,
   parameter int PTR_W = 4
) (
   input  logic [N_ENT-1:0] cand,
   input  logic [PTR_W-1:0] ptr,
   input  logic             halted,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N_ENT - 1; i >= 0; i--) begin
         if (cand[i] && (PTR_W'(i) >= ptr) && !halted) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/idr_serializer.sv
module idr_serializer
   import idr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  id_word_t   word,
   output logic       id_valid,
   output logic [3:0] id_nib
);
   logic [19:0] shr;
   logic [2:0]  left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shr  <= '0;
         left <= '0;
      end else if (start) begin
         shr  <= {word.last, word.cls, word.typ, 4'h0, word.size};
         left <= 3'd5;
      end else if (left != 3'd0) begin
         shr  <= {4'h0, shr[19:4]};
         left <= left - 1'b1;
      end
   end

   assign id_valid = (left != 3'd0);
   assign id_nib   = shr[3:0];
endmodule

// File: rtl/idr_chain_responder.sv
module idr_chain_responder
   import idr_pkg::*;
#(
   parameter int N_ENT     = 8,
   parameter int ADDR_NIBS = 5,
   parameter int SAMPLE_PT = 3,
   parameter logic [4*ADDR_NIBS-1:0] HW_BASE = 'hE0000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [4*N_ENT-1:0]           tbl_size,
   input  logic [4*N_ENT-1:0]           tbl_type,
   input  logic [4*N_ENT-1:0]           tbl_class,
   input  logic [4*N_ENT-1:0]           tbl_last,
   input  logic [2*N_ENT-1:0]           tbl_flag,
   input  logic                         bus_strobe,
   input  logic [1:0]                   bus_cmd,
   input  logic [3:0]                   bus_nib,
   input  logic                         daisy_in,
   output logic                         daisy_out,
   output logic                         id_valid,
   output logic [3:0]                   id_nib,
   output logic [N_ENT-1:0]             map_vld,
   output logic [4*ADDR_NIBS*N_ENT-1:0] map_base
);
   localparam int ADDR_W = 4 * ADDR_NIBS;
   localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1;
   localparam int PTR_W  = IDX_W + 1;
   localparam int NC_W   = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
   localparam logic [NC_W-1:0] LAST_NIB = NC_W'(ADDR_NIBS - 1);

   if (N_ENT < 1 || N_ENT > 16) begin : g_bad_nent
      $error("N_ENT must lie in 1..16");
   end
   if (ADDR_NIBS < 1 || ADDR_NIBS > 8) begin : g_bad_anib
      $error("ADDR_NIBS must lie in 1..8");
   end
   if (SAMPLE_PT < 0 || SAMPLE_PT > 64) begin : g_bad_spt
      $error("SAMPLE_PT must lie in 0..64");
   end

   // host strobe sampling
   logic       smp_valid;
   bus_cmd_e   smp_cmd;
   logic [3:0] smp_nib;

   idr_sampler #(.SAMPLE_PT(SAMPLE_PT)) u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (bus_strobe),
      .cmd_in   (bus_cmd),
      .nib_in   (bus_nib),
      .smp_valid(smp_valid),
      .smp_cmd  (smp_cmd),
      .smp_nib  (smp_nib)
   );

   // per-entry classification
   logic [N_ENT-1:0]  cand;
   logic [N_ENT-1:0]  hard;
   logic [N_ENT-1:0]  cfg_map;
   logic [ADDR_W-1:0] base_q [N_ENT];

   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      logic      size_ok;
      ent_flag_e fl;
      assign size_ok = (tbl_size[4*g +: 4] >= MIN_SIZE);
      assign fl      = ent_flag_e'(tbl_flag[2*g +: 2]);
      assign cand[g] = size_ok && (fl == FL_CONT || fl == FL_STOP);
      assign hard[g] = size_ok && (fl == FL_HARD);
      assign map_vld[g] = hard[g] | cfg_map[g];
      assign map_base[ADDR_W*g +: ADDR_W] = hard[g] ? HW_BASE : base_q[g];
   end

   // current entry
   logic [PTR_W-1:0] ptr;
   logic             halted;
   logic             found;
   logic [IDX_W-1:0] cur;

   idr_picker #(.N_ENT(N_ENT), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_pick (
      .cand  (cand),
      .ptr   (ptr),
      .halted(halted),
      .found (found),
      .idx   (cur)
   );

   assign daisy_out = daisy_in & ~found;

   // identification output
   id_word_t cur_word;
   logic     ser_start;

   always_comb begin
      cur_word.size = tbl_size [4*cur +: 4];
      cur_word.typ  = tbl_type [4*cur +: 4];
      cur_word.cls  = tbl_class[4*cur +: 4];
      cur_word.last = tbl_last [4*cur +: 4] & 4'b1100;
   end

   assign ser_start = smp_valid && (smp_cmd == CMD_ID) && daisy_in && found && !id_valid;

   idr_serializer u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (ser_start),
      .word    (cur_word),
      .id_valid(id_valid),
      .id_nib  (id_nib)
   );

   // configure / unconfigure
   logic [ADDR_W-1:0] acc;
   logic [ADDR_W-1:0] acc_nxt;
   logic [NC_W-1:0]   nib_cnt;
   logic              cur_stop;
   logic              uncfg_hit;

   assign acc_nxt   = acc | (ADDR_W'(smp_nib) << (4 * nib_cnt));
   assign cur_stop  = (ent_flag_e'(tbl_flag[2*cur +: 2]) == FL_STOP);
   assign uncfg_hit = ({28'd0, smp_nib} < 32'(N_ENT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         halted  <= 1'b0;
         acc     <= '0;
         nib_cnt <= '0;
         cfg_map <= '0;
         for (int i = 0; i < N_ENT; i++) base_q[i] <= '0;
      end else if (smp_valid) begin
         case (smp_cmd)
            CMD_CFG: begin
               if (daisy_in && found) begin
                  if (nib_cnt == LAST_NIB) begin
                     base_q[cur]  <= acc_nxt;
                     cfg_map[cur] <= 1'b1;
                     ptr          <= PTR_W'(cur) + PTR_W'(1);
                     if (cur_stop) halted <= 1'b1;
                     acc          <= '0;
                     nib_cnt      <= '0;
                  end else begin
                     acc     <= acc_nxt;
                     nib_cnt <= nib_cnt + 1'b1;
                  end
               end
            end
            CMD_UNCFG: begin
               if (uncfg_hit) begin
                  cfg_map[smp_nib[IDX_W-1:0]] <= 1'b0;
                  base_q[smp_nib[IDX_W-1:0]]  <= '0;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/idr_chain_chk.sv
module idr_chain_chk #(
   parameter int N_ENT = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               daisy_in,
   input logic               daisy_out,
   input logic               id_valid,
   input logic [3:0]         id_nib,
   input logic [4*N_ENT-1:0] tbl_size,
   input logic [2*N_ENT-1:0] tbl_flag,
   input logic [N_ENT-1:0]   map_vld
);
   logic [2:0] beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) beat <= '0;
      else if (id_valid) begin
         if (beat != 3'd7) beat <= beat + 1'b1;
      end else beat <= '0;
   end

   // R2
   id_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |-> beat < 3'd5);

   // R2
   id_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!id_valid && $past(id_valid)) |-> beat == 3'd5);

   // R3
   last_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_valid && beat == 3'd4) |-> id_nib[1:0] == 2'b00);

   // R11
   daisy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !daisy_in |-> !daisy_out);

   for (genvar g = 0; g < N_ENT; g++) begin : g_chk
      // R7
      hard_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tbl_size[4*g +: 4] >= 4'h7 && tbl_flag[2*g +: 2] == 2'd2) |-> map_vld[g]);

      // R11
      map_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(map_vld[g]) && tbl_flag[2*g +: 2] != 2'd2 && $past(tbl_flag[2*g +: 2]) != 2'd2)
         |-> $past(daisy_in));
   end
endmodule

bind idr_chain_responder idr_chain_chk #(.N_ENT(N_ENT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .daisy_in (daisy_in),
   .daisy_out(daisy_out),
   .id_valid (id_valid),
   .id_nib   (id_nib),
   .tbl_size (tbl_size),
   .tbl_flag (tbl_flag),
   .map_vld  (map_vld)
);

// File: tb/idr_chain_responder_tb.sv
`timescale 1ns/1ps
module idr_chain_responder_tb;
   localparam int N_ENT  = 8;
   localparam int ANIB   = 3;
   localparam int SP     = 2;
   localparam int AW     = 4 * ANIB;
   localparam logic [AW-1:0] HWB = 12'hE00;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4*N_ENT-1:0] tbl_size  = 32'hA8AAA95A;
   logic [4*N_ENT-1:0] tbl_type  = 32'h1111F111;
   logic [4*N_ENT-1:0] tbl_class = 32'h00000000;
   logic [4*N_ENT-1:0] tbl_last  = 32'h08088F88;
   logic [2*N_ENT-1:0] tbl_flag  = 16'hB840;
   logic bus_strobe = 1'b0;
   logic [1:0] bus_cmd = 2'd0;
   logic [3:0] bus_nib = 4'h0;
   logic daisy_in = 1'b0;
   logic daisy_out, id_valid;
   logic [3:0] id_nib;
   logic [N_ENT-1:0] map_vld;
   logic [AW*N_ENT-1:0] map_base;

   always #2.5 clk = ~clk;

   idr_chain_responder #(.N_ENT(N_ENT), .ADDR_NIBS(ANIB), .SAMPLE_PT(SP), .HW_BASE(HWB)) u_dut (
      .clk(clk), .rst_n(rst_n), .tbl_size(tbl_size), .tbl_type(tbl_type),
      .tbl_class(tbl_class), .tbl_last(tbl_last), .tbl_flag(tbl_flag),
      .bus_strobe(bus_strobe), .bus_cmd(bus_cmd), .bus_nib(bus_nib),
      .daisy_in(daisy_in), .daisy_out(daisy_out), .id_valid(id_valid),
      .id_nib(id_nib), .map_vld(map_vld), .map_base(map_base)
   );

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [3:0] exp_q[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && id_valid === 1'b1) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R2 unexpected nibble act=%h exp=none", id_nib);
         end else begin
            logic [3:0] e;
            e = exp_q.pop_front();
            if (id_nib !== e) begin
               bad++;
               $display("FAIL R2 id nibble act=%h exp=%h", id_nib, e);
            end
         end
      end
   end

   task automatic bus_op(input logic [1:0] c, input logic [3:0] n);
      @(negedge clk);
      bus_strobe = 1'b1; bus_cmd = 2'd0; bus_nib = ~n;
      repeat (SP) @(negedge clk);
      bus_cmd = c; bus_nib = n;
      repeat (2) @(negedge clk);
      bus_strobe = 1'b0; bus_cmd = 2'd0; bus_nib = 4'h0;
      repeat (8) @(negedge clk);
   endtask

   task automatic send_id(input bit resp, input logic [3:0] sz, input logic [3:0] ty,
                          input logic [3:0] cl, input logic [3:0] la);
      if (resp) begin
         exp_q.push_back(sz); exp_q.push_back(4'h0); exp_q.push_back(ty);
         exp_q.push_back(cl); exp_q.push_back(la);
      end
      bus_op(2'd1, 4'h0);
   endtask

   task automatic send_cfg(input logic [AW-1:0] b);
      for (int k = 0; k < ANIB; k++) bus_op(2'd2, b[4*k +: 4]);
   endtask

   function automatic logic [AW-1:0] base_of(input int i);
      return map_base[AW*i +: AW];
   endfunction

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 map_vld", 32'(map_vld), 32'hA0);
      chk("R1 base0", 32'(base_of(0)), 32'h0);
      chk("R1 id_valid", 32'(id_valid), 32'h0);
      chk("R7 hard base5", 32'(base_of(5)), 32'(HWB));
      chk("R11 daisy_out low", 32'(daisy_out), 32'h0);
      // R11 daisy_in low ignores ID and configure
      send_id(1'b0, 4'h0, 4'h0, 4'h0, 4'h0);
      send_cfg(12'h111);
      chk("R11 map unchanged", 32'(map_vld), 32'hA0);
      chk("R11 base0 unchanged", 32'(base_of(0)), 32'h0);
      daisy_in = 1'b1;
      @(negedge clk);
      chk("R11 daisy_out with entries", 32'(daisy_out), 32'h0);
      // R10 short strobe is not sampled
      @(negedge clk);
      bus_strobe = 1'b1; bus_cmd = 2'd1; bus_nib = 4'h0;
      repeat (SP) @(negedge clk);
      bus_strobe = 1'b0; bus_cmd = 2'd0;
      repeat (10) @(negedge clk);
      chk("R10 short strobe silent", 32'(exp_q.size()), 32'h0);
      // R2 first entry, R4 configure
      send_id(1'b1, 4'hA, 4'h1, 4'h0, 4'h8);
      chk("R2 drained", 32'(exp_q.size()), 32'h0);
      send_cfg(12'h123);
      chk("R4 base0", 32'(base_of(0)), 32'h123);
      chk("R4 map0", 32'(map_vld[0]), 32'h1);
      // R5 skips entry1, R3 masks low bits of entry2
      send_id(1'b1, 4'h9, 4'h1, 4'h0, 4'hC);
      chk("R3 R5 drained", 32'(exp_q.size()), 32'h0);
      send_cfg(12'hABC);
      chk("R4 base2", 32'(base_of(2)), 32'hABC);
      // stop entry 3
      send_id(1'b1, 4'hA, 4'hF, 4'h0, 4'h8);
      send_cfg(12'h456);
      chk("R4 base3", 32'(base_of(3)), 32'h456);
      chk("R6 daisy_out high", 32'(daisy_out), 32'h1);
      chk("R6 map after stop", 32'(map_vld), 32'hAD);
      // R8 probes after end stay silent
      send_id(1'b0, 4'h0, 4'h0, 4'h0, 4'h0);
      send_id(1'b0, 4'h0, 4'h0, 4'h0, 4'h0);
      chk("R8 silent probes", 32'(exp_q.size()), 32'h0);
      chk("R8 daisy_out stays", 32'(daisy_out), 32'h1);
      send_cfg(12'h111);
      chk("R6 entry4 unmapped", 32'(map_vld), 32'hAD);
      chk("R6 base4 zero", 32'(base_of(4)), 32'h0);
      // R9 unconfigure
      bus_op(2'd3, 4'h2);
      chk("R9 map2 cleared", 32'(map_vld), 32'hA9);
      chk("R9 base2 cleared", 32'(base_of(2)), 32'h0);
      bus_op(2'd3, 4'h5);
      chk("R7 hard survives unconfig", 32'(map_vld), 32'hA9);
      chk("R7 hard base", 32'(base_of(5)), 32'(HWB));
      // R1 reset returns pointer to start
      do_reset();
      chk("R1 map after reset", 32'(map_vld), 32'hA0);
      chk("R1 base0 after reset", 32'(base_of(0)), 32'h0);
      chk("R1 daisy_out after reset", 32'(daisy_out), 32'h0);
      send_id(1'b1, 4'hA, 4'h1, 4'h0, 4'h8);
      chk("R1 first entry again", 32'(exp_q.size()), 32'h0);
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule